// File: doc/BRIEF.md
# Programmable Switch Matrix

This block is a small programmable routing point. A set of incoming wires, four by default, is fanned out to a set of outgoing wires, three by default. Each outgoing wire has its own multiplexer. Its select code is held in a configuration register, so any output can carry any input, and several outputs can carry the same input at once.

The configuration is not written through a parallel port. It is shifted in one bit per clock through a serial input while a shift enable is high. The bit that leaves the far end of the register appears on a serial output. Several matrices, or a matrix and other configurable cells, can therefore be strung into one long configuration chain and loaded with a single stream of bits. Once loading ends, the path from inputs to outputs is purely combinational. While a load is in progress the outputs are not meaningful.

Top module: `swm_switch_matrix`

## Requirements
- R1: A synchronous active-high reset clears every select code to 0, so every output follows input 0 and the serial output reads 0 until the first shift.
- R2: A select code of value v routes input v to the output, so 0, 1, 2 and 3 choose inputs 0, 1, 2 and 3.
- R3: Each output's code is independent of the others, and two or more outputs may carry the same input at the same time.
- R4: With the shift enable high, each rising clock moves one bit in from the serial input. For a 6-bit stream whose bit 5 is shifted first, output 0 takes code bits [5:4], output 1 takes bits [3:2] and output 2 takes bits [1:0], each pair with its high bit first.
- R5: The serial output shows the oldest bit held in the register. During the six shifts of a new load, it presents the previous configuration's bits in the order they were shifted in.
- R6: While the shift enable is low, the configuration and the serial output keep their values, whatever the serial input does.
- R7: Routing is combinational. A change on an input reaches the routed output in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift_en | input | 1 | Shift the configuration register by one bit per clock |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out, toward the next cell in the chain |
| m_in | input | N_IN*DW | Incoming wires, input k in bits [k*DW +: DW] |
| o_out | output | N_OUT*DW | Outgoing wires, output k in bits [k*DW +: DW] |

## Verification
The assertions check four things on every cycle: the cleared state after reset, the entry of each serial bit at the bottom of the register, the hand-off of the top bit to the serial output, and that the configuration holds when shifting is off. They also check that output 0 always equals the input its current code names. Only the bench's scenarios can show that the bit order maps onto the right outputs. The bench loads all 64 configurations and applies all 16 input patterns under each one. It also shows that a stream passes through the chain as whole configurations, and that routing settles within half a cycle with no clock edge in between.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int unsigned SWM_DEF_N_IN  = 4;
  localparam int unsigned SWM_DEF_N_OUT = 3;
  localparam int unsigned SWM_DEF_DW    = 1;

  function automatic int unsigned swm_sel_width(input int unsigned n_in);
    return (n_in > 1) ? $clog2(n_in) : 1;
  endfunction
endpackage

// File: rtl/swm_cfg_chain.sv
module swm_cfg_chain #(
  parameter int unsigned TOT = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           shift_in,
  output logic           shift_out,
  output logic [TOT-1:0] cfg_bits
);
  logic [TOT-1:0] chain_q;

  generate
    if (TOT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           chain_q <= '0;
        else if (shift_en) chain_q <= shift_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           chain_q <= '0;
        else if (shift_en) chain_q <= {chain_q[TOT-2:0], shift_in};
      end
    end
  endgenerate

  assign cfg_bits  = chain_q;
  assign shift_out = chain_q[TOT-1];
endmodule

// File: rtl/swm_mux.sv
module swm_mux #(
  parameter int unsigned N_IN = 4,
  parameter int unsigned DW   = 1,
  parameter int unsigned SW   = 2
) (
  input  logic [N_IN*DW-1:0] din,
  input  logic [SW-1:0]      sel,
  output logic [DW-1:0]      dout
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (sel == SW'(k)) dout = din[k*DW +: DW];
    end
  end
endmodule

// File: rtl/swm_switch_matrix.sv
module swm_switch_matrix #(
  parameter int unsigned N_IN  = swm_pkg::SWM_DEF_N_IN,
  parameter int unsigned N_OUT = swm_pkg::SWM_DEF_N_OUT,
  parameter int unsigned DW    = swm_pkg::SWM_DEF_DW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_shift_en,
  input  logic                cfg_sin,
  output logic                cfg_sout,
  input  logic [N_IN*DW-1:0]  m_in,
  output logic [N_OUT*DW-1:0] o_out
);
  localparam int unsigned SW  = swm_pkg::swm_sel_width(N_IN);
  localparam int unsigned TOT = N_OUT * SW;

  logic [TOT-1:0] cfg_bits;

  swm_cfg_chain #(.TOT(TOT)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_shift_en),
    .shift_in (cfg_sin),
    .shift_out(cfg_sout),
    .cfg_bits (cfg_bits)
  );

  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
      swm_mux #(.N_IN(N_IN), .DW(DW), .SW(SW)) u_mux (
        .din (m_in),
        .sel (cfg_bits[TOT-1-k*SW -: SW]),
        .dout(o_out[k*DW +: DW])
      );
    end
  endgenerate
endmodule

// File: rtl/swm_switch_matrix_chk.sv
module swm_switch_matrix_chk #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 3,
  parameter int unsigned DW    = 1
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_shift_en,
  input logic                cfg_sin,
  input logic                cfg_sout,
  input logic [N_OUT*swm_pkg::swm_sel_width(N_IN)-1:0] cfg_bits,
  input logic [N_IN*DW-1:0]  m_in,
  input logic [N_OUT*DW-1:0] o_out
);
  localparam int unsigned SW  = swm_pkg::swm_sel_width(N_IN);
  localparam int unsigned TOT = N_OUT * SW;

  logic [SW-1:0] sel0;
  logic [DW-1:0] pick0;
  assign sel0 = cfg_bits[TOT-1 -: SW];
  always_comb begin
    pick0 = '0;
    for (int k = 0; k < N_IN; k++) if (int'(sel0) == k) pick0 = m_in[k*DW +: DW];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_bits == '0 && cfg_sout == 1'b0)); // R1
  AST_ROUTE_OUT0: assert property (@(posedge clk) disable iff (rst)
    !cfg_shift_en |-> (o_out[DW-1:0] == pick0)); // R2
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    cfg_shift_en |=> (cfg_bits[0] == $past(cfg_sin))); // R4
  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (rst)
    cfg_shift_en |=> (cfg_sout == $past(cfg_bits[TOT-2]))); // R5
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
    !cfg_shift_en |=> ($stable(cfg_bits) && $stable(cfg_sout))); // R6
endmodule

bind swm_switch_matrix swm_switch_matrix_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_shift_en(cfg_shift_en),
  .cfg_sin     (cfg_sin),
  .cfg_sout    (cfg_sout),
  .cfg_bits    (cfg_bits),
  .m_in        (m_in),
  .o_out       (o_out)
);

// File: tb/tb_swm_switch_matrix.sv
module tb_swm_switch_matrix;
  typedef struct {
    bit       is_sout;
    bit [2:0] exp;
    string    tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_shift_en = 1'b0;
  logic       cfg_sin = 1'b0;
  logic       cfg_sout;
  logic [3:0] m_in = 4'h0;
  logic [2:0] o_out;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  swm_switch_matrix dut (
    .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_sin(cfg_sin),
    .cfg_sout(cfg_sout), .m_in(m_in), .o_out(o_out)
  );

  function automatic bit [2:0] route(input bit [5:0] c, input bit [3:0] m);
    bit [2:0] r;
    for (int k = 0; k < 3; k++) r[k] = m[c[5-2*k -: 2]];
    return r;
  endfunction

  task automatic push(input bit s, input bit [2:0] e, input string t);
    item_t it;
    it.is_sout = s; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic apply(input bit [5:0] c, input bit [3:0] m, input string t);
    @(posedge clk); #1;
    cfg_shift_en = 1'b0;
    cfg_sin = 1'($urandom);
    m_in = m;
    push(1'b0, route(c, m), t);
  endtask

  task automatic load(input bit [5:0] c, input bit [5:0] old);
    for (int j = 0; j < 6; j++) begin
      @(posedge clk); #1;
      cfg_shift_en = 1'b1;
      cfg_sin = c[5-j];
      push(1'b1, {2'b00, old[5-j]}, "R5 scan-out replays previous configuration");
    end
  endtask

  // monitor: one item per cycle, sampled half a cycle after the drive (R7)
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        bit [2:0] act;
        it = q.pop_front();
        act = it.is_sout ? {2'b00, cfg_sout} : o_out;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [5:0] old;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: after reset every output follows input 0, scan-out reads 0
    @(posedge clk); #1;
    push(1'b1, 3'b000, "R1 scan-out clear after reset");
    for (int m = 0; m < 16; m++) apply(6'd0, 4'(m), "R1 reset codes route input 0");
    old = 6'd0;
    // R2/R3/R4/R7: every configuration, every input pattern
    for (int c = 0; c < 64; c++) begin
      load(6'(c), old);
      for (int m = 0; m < 16; m++)
        apply(6'(c), 4'(m), "R2 R3 R4 R7 routing follows code");
      old = 6'(c);
    end
    // R6: configuration holds with shift disabled while cfg_sin toggles
    for (int n = 0; n < 40; n++) apply(old, 4'($urandom), "R6 hold while shift disabled");
    @(posedge clk); #1;
    push(1'b1, {2'b00, old[5]}, "R6 scan-out holds while shift disabled");
    // R3: shared source, all outputs carry input 2 (stream 101010)
    load(6'b101010, old);
    apply(6'b101010, 4'b0100, "R3 shared source, input 2 on all outputs");
    apply(6'b101010, 4'b1011, "R3 shared source, input 2 low on all outputs");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule